// File: doc/BRIEF.md
# Machine Check Error Collector

This block gathers the scattered error-check lines of a microprogrammed processor into three summary latches, sorted by when in the machine cycle each check fires. Control checks, early checks and late checks each have their own latch. The collector then decides the machine's reaction to what it has latched. It can halt the cycle clock, freeze the control-store sense latches so the failing microword stays visible, request a log-out of machine state, or enter a hard stop.

The block also decodes a few microword control fields. One code pair requests a log-out. Another code pair acts as a programmed stop. A third field, qualified by a manual status bit, clears the error status. An error-enable mode bit selects the reaction. With errors enabled, checks halt the machine and start a log-out. With errors disabled, checks are only recorded, and a log-out request waits until the mode returns to enabled. A sticky error-status flag marks that a log-out is already in progress. While that flag is set, a further error forces a hard stop instead of a second log-out.

All state is synchronous to one clock. The stop-clock output is derived only from registered latches, so the halt always falls on a cycle boundary.

Top module: `mchk_collector`

## Requirements
- R1: A nonzero control, early or late check group sets its own summary latch (`ctlLatch`, `earlyLatch`, `lateLatch`) at the next clock edge. The latch then holds until a check-latch reset.
- R2: `stopClk` is high exactly when errors are enabled and at least one summary latch is set. It carries no combinational path from the check inputs.
- R3: `masterLatch` sets at the clock edge after any summary latch is observed set. It clears with the summary latches.
- R4: `csInhibit` rises in the same cycle as a control check, an early check or a STOP command, and stays high while the control or early latch is set. It is active only with errors enabled. A late check alone never raises it.
- R5: Field B = 2 with field D = 3 is the LOG command. With errors enabled, the error status clear and no hard stop, it gives a one-cycle `logReq` pulse after the next edge and sets the error status.
- R6: Field B = 5 with field D = 3 is the STOP command. It sets the early latch in either mode. It sets `hardStop` only while errors are enabled.
- R7: With errors disabled, checks are still latched, `stopClk` and `logReq` stay low, and LOG sets the control latch and is held pending. The pending log-out is issued on the first cycle the mode is enabled again, provided the status is clear.
- R8: `errStatus` is set by system reset and by the start of each log-out. It is cleared only by the reset-errors command. While it is set, log-out requests are dropped, and a new error with errors enabled sets `hardStop`. A new error is a check while no summary latch is set.
- R9: With errors enabled and the status clear, a new error raises `logReq` after the next edge.
- R10: System reset, the check-reset button, the reset-errors command and the log-out clock-start input each clear all summary latches and the master latch. `hardStop` is cleared by the first three only.
- R11: Field R = 6 together with `manualStat` is the reset-errors command. It has no effect while `stopClk` is high.
- R12: When a check-latch reset and an error arrive in the same cycle, the reset wins. A check still present in the following cycle is latched at the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| sysReset | input | 1 | System reset, synchronous, active high |
| ctlChecks | input | CTL_W | Control-class check lines |
| earlyChecks | input | EARLY_W | Early-class check lines |
| lateChecks | input | LATE_W | Late-class check lines |
| fldB | input | FLD_B_W | Decoded microword field B |
| fldD | input | FLD_D_W | Decoded microword field D |
| fldR | input | FLD_R_W | Decoded microword field R |
| manualStat | input | 1 | Manual status bit qualifying reset-errors |
| errEnable | input | 1 | 1 = errors enabled, 0 = errors disabled |
| checkResetBtn | input | 1 | Check-reset pushbutton |
| logStartClk | input | 1 | Clock-start signal from the log-out sequencer |
| stopClk | output | 1 | Request to halt the cycle clock |
| csInhibit | output | 1 | Blocks update of the control-store sense latches |
| logReq | output | 1 | One-cycle log-out start request |
| hardStop | output | 1 | Hard-stop flag |
| ctlLatch | output | 1 | Control check summary latch |
| earlyLatch | output | 1 | Early check summary latch |
| lateLatch | output | 1 | Late check summary latch |
| masterLatch | output | 1 | Master check latch |
| errStatus | output | 1 | Sticky error-status flag |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `sysReset` is held high for the first edges, so that every latch starts from a known value before any property is evaluated. The stimulus changes inputs only on falling edges. It opens with two cycles of system reset and keeps each command field pattern for exactly one cycle unless a step deliberately holds it, so each check sees a single, well-defined decode per edge.

// File: rtl/mchk_pkg.sv
package mchk_pkg;

  localparam int unsigned NUM_GRP = 3;
  localparam int unsigned GRP_CTL = 0;
  localparam int unsigned GRP_EARLY = 1;
  localparam int unsigned GRP_LATE = 2;

  // strobes from the control into the latch datapath
  typedef struct packed {
    logic [NUM_GRP-1:0] setSum;
    logic clrChk;
    logic setStatus;
    logic clrStatus;
    logic setHard;
    logic clrHard;
    logic setPend;
    logic clrPend;
    logic logPulse;
  } mchk_strobe_t;

  // registered state fed back to the control
  typedef struct packed {
    logic [NUM_GRP-1:0] sum;
    logic master;
    logic errStatus;
    logic hardStop;
    logic pend;
    logic stopClk;
  } mchk_state_t;

endpackage

// File: rtl/mchk_ctrl.sv
module mchk_ctrl
  import mchk_pkg::*;
#(
  parameter int unsigned CTL_W = 4,
  parameter int unsigned EARLY_W = 3,
  parameter int unsigned LATE_W = 5,
  parameter int unsigned FLD_B_W = 3,
  parameter int unsigned FLD_D_W = 2,
  parameter int unsigned FLD_R_W = 3,
  parameter int unsigned LOG_B = 2,
  parameter int unsigned STOP_B = 5,
  parameter int unsigned CMD_D = 3,
  parameter int unsigned RSTERR_R = 6
) (
  input  logic               clk,
  input  logic               sysReset,
  input  logic [CTL_W-1:0]   ctlChecks,
  input  logic [EARLY_W-1:0] earlyChecks,
  input  logic [LATE_W-1:0]  lateChecks,
  input  logic [FLD_B_W-1:0] fldB,
  input  logic [FLD_D_W-1:0] fldD,
  input  logic [FLD_R_W-1:0] fldR,
  input  logic               manualStat,
  input  logic               errEnable,
  input  logic               checkResetBtn,
  input  logic               logStartClk,
  input  mchk_state_t        st,
  output mchk_strobe_t       strb,
  output logic               csInhibit
);

  localparam logic [FLD_B_W-1:0] LOG_CODE  = FLD_B_W'(LOG_B);
  localparam logic [FLD_B_W-1:0] STOP_CODE = FLD_B_W'(STOP_B);
  localparam logic [FLD_D_W-1:0] CMD_CODE  = FLD_D_W'(CMD_D);
  localparam logic [FLD_R_W-1:0] RST_CODE  = FLD_R_W'(RSTERR_R);

  logic [NUM_GRP-1:0] grpHit;
  logic logCmd, stopCmd, resetErrCmd, running;
  logic errRst, chkRst, anyLatch, newErr, logTrig, hardTrig;

  assign grpHit[GRP_CTL]   = |ctlChecks;
  assign grpHit[GRP_EARLY] = |earlyChecks;
  assign grpHit[GRP_LATE]  = |lateChecks;

  assign logCmd  = (fldB == LOG_CODE)  && (fldD == CMD_CODE);
  assign stopCmd = (fldB == STOP_CODE) && (fldD == CMD_CODE);
  assign running = !st.stopClk;
  assign resetErrCmd = (fldR == RST_CODE) && manualStat && running;

  assign errRst   = sysReset | checkResetBtn | resetErrCmd;
  assign chkRst   = errRst | logStartClk;
  assign anyLatch = |st.sum;
  assign newErr   = (|grpHit) && !anyLatch;

  assign logTrig  = errEnable && !sysReset && !st.errStatus && !st.hardStop &&
                    (logCmd || st.pend || newErr);
  assign hardTrig = errEnable && !sysReset &&
                    ((st.errStatus && newErr) || stopCmd);

  always_comb begin
    strb = '0;
    strb.setSum[GRP_CTL]   = grpHit[GRP_CTL] | (logCmd & !errEnable);
    strb.setSum[GRP_EARLY] = grpHit[GRP_EARLY] | stopCmd;
    strb.setSum[GRP_LATE]  = grpHit[GRP_LATE];
    strb.clrChk    = chkRst;
    strb.setStatus = sysReset | logTrig;
    strb.clrStatus = resetErrCmd;
    strb.setHard   = hardTrig;
    strb.clrHard   = errRst;
    strb.setPend   = logCmd & !errEnable;
    strb.clrPend   = logTrig | chkRst;
    strb.logPulse  = logTrig;
  end

  assign csInhibit = errEnable &&
                     (grpHit[GRP_CTL] || grpHit[GRP_EARLY] || stopCmd ||
                      st.sum[GRP_CTL] || st.sum[GRP_EARLY]);

  // R11: with the clock halted only reset, the button or log clock start clear the latches
  assert_reset_err_gated_R11: assert property (@(posedge clk) disable iff (sysReset)
    (st.stopClk && !checkResetBtn && !logStartClk) |-> !strb.clrChk);

endmodule

// File: rtl/mchk_latches.sv
module mchk_latches
  import mchk_pkg::*;
(
  input  logic               clk,
  input  logic               sysReset,
  input  logic               errEnable,
  input  mchk_strobe_t       strb,
  output logic [NUM_GRP-1:0] sumLatch,
  output logic               master,
  output logic               errStatus,
  output logic               hardStop,
  output logic               pend,
  output logic               logReq,
  output logic               stopClk
);

  logic anyLatch;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_sum
    always_ff @(posedge clk) begin
      if (strb.clrChk) sumLatch[g] <= 1'b0;
      else if (strb.setSum[g]) sumLatch[g] <= 1'b1;
    end

    // R1: a summary latch holds until a check-latch reset
    assert_sum_hold_R1: assert property (@(posedge clk) disable iff (sysReset)
      (sumLatch[g] && !strb.clrChk) |=> sumLatch[g]);
  end

  assign anyLatch = |sumLatch;

  always_ff @(posedge clk) begin
    if (strb.clrChk) master <= 1'b0;
    else if (anyLatch) master <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.setStatus) errStatus <= 1'b1;
    else if (strb.clrStatus) errStatus <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (strb.clrHard) hardStop <= 1'b0;
    else if (strb.setHard) hardStop <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.clrPend) pend <= 1'b0;
    else if (strb.setPend) pend <= 1'b1;
  end

  always_ff @(posedge clk) logReq <= strb.logPulse;

  assign stopClk = errEnable & anyLatch;

  // R12: a check-latch reset empties every summary and master latch
  assert_reset_wins_R12: assert property (@(posedge clk) disable iff (sysReset)
    strb.clrChk |=> (sumLatch == '0) && !master);

  // R3: master follows any summary latch one edge later
  assert_master_follows_R3: assert property (@(posedge clk) disable iff (sysReset)
    (anyLatch && !strb.clrChk) |=> master);

  // R8: error status only falls through the reset-errors command
  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (sysReset)
    (errStatus && !strb.clrStatus) |=> errStatus);

  // R5: every log-out request comes with the status flag set
  assert_log_marks_status_R5: assert property (@(posedge clk) disable iff (sysReset)
    logReq |-> errStatus);

endmodule

// File: rtl/mchk_collector.sv
module mchk_collector
  import mchk_pkg::*;
#(
  parameter int unsigned CTL_W = 4,
  parameter int unsigned EARLY_W = 3,
  parameter int unsigned LATE_W = 5,
  parameter int unsigned FLD_B_W = 3,
  parameter int unsigned FLD_D_W = 2,
  parameter int unsigned FLD_R_W = 3,
  parameter int unsigned LOG_B = 2,
  parameter int unsigned STOP_B = 5,
  parameter int unsigned CMD_D = 3,
  parameter int unsigned RSTERR_R = 6
) (
  input  logic               clk,
  input  logic               sysReset,
  input  logic [CTL_W-1:0]   ctlChecks,
  input  logic [EARLY_W-1:0] earlyChecks,
  input  logic [LATE_W-1:0]  lateChecks,
  input  logic [FLD_B_W-1:0] fldB,
  input  logic [FLD_D_W-1:0] fldD,
  input  logic [FLD_R_W-1:0] fldR,
  input  logic               manualStat,
  input  logic               errEnable,
  input  logic               checkResetBtn,
  input  logic               logStartClk,
  output logic               stopClk,
  output logic               csInhibit,
  output logic               logReq,
  output logic               hardStop,
  output logic               ctlLatch,
  output logic               earlyLatch,
  output logic               lateLatch,
  output logic               masterLatch,
  output logic               errStatus
);

  mchk_strobe_t strb;
  mchk_state_t  st;
  logic [NUM_GRP-1:0] sumLatch;
  logic pend;

  assign st.sum       = sumLatch;
  assign st.master    = masterLatch;
  assign st.errStatus = errStatus;
  assign st.hardStop  = hardStop;
  assign st.pend      = pend;
  assign st.stopClk   = stopClk;

  mchk_ctrl #(
    .CTL_W(CTL_W), .EARLY_W(EARLY_W), .LATE_W(LATE_W),
    .FLD_B_W(FLD_B_W), .FLD_D_W(FLD_D_W), .FLD_R_W(FLD_R_W),
    .LOG_B(LOG_B), .STOP_B(STOP_B), .CMD_D(CMD_D), .RSTERR_R(RSTERR_R)
  ) u_ctrl (
    .clk(clk), .sysReset(sysReset),
    .ctlChecks(ctlChecks), .earlyChecks(earlyChecks), .lateChecks(lateChecks),
    .fldB(fldB), .fldD(fldD), .fldR(fldR), .manualStat(manualStat),
    .errEnable(errEnable), .checkResetBtn(checkResetBtn), .logStartClk(logStartClk),
    .st(st), .strb(strb), .csInhibit(csInhibit)
  );

  mchk_latches u_latches (
    .clk(clk), .sysReset(sysReset), .errEnable(errEnable), .strb(strb),
    .sumLatch(sumLatch), .master(masterLatch), .errStatus(errStatus),
    .hardStop(hardStop), .pend(pend), .logReq(logReq), .stopClk(stopClk)
  );

  assign ctlLatch   = sumLatch[GRP_CTL];
  assign earlyLatch = sumLatch[GRP_EARLY];
  assign lateLatch  = sumLatch[GRP_LATE];

endmodule

// File: tb/test_mchk_collector.sv
`timescale 1ns/1ps
module test_mchk_collector;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic sys, man, en, cbtn, lsc;
  logic [3:0] cIn;
  logic [2:0] eIn;
  logic [4:0] lIn;
  logic [2:0] fB, fR;
  logic [1:0] fD;
  logic stopClk, csInhibit, logReq, hardStop, ctlLatch, earlyLatch, lateLatch, masterLatch, errStatus;

  mchk_collector i_mchk_collector (
    .clk(clk), .sysReset(sys), .ctlChecks(cIn), .earlyChecks(eIn), .lateChecks(lIn),
    .fldB(fB), .fldD(fD), .fldR(fR), .manualStat(man), .errEnable(en),
    .checkResetBtn(cbtn), .logStartClk(lsc),
    .stopClk(stopClk), .csInhibit(csInhibit), .logReq(logReq), .hardStop(hardStop),
    .ctlLatch(ctlLatch), .earlyLatch(earlyLatch), .lateLatch(lateLatch),
    .masterLatch(masterLatch), .errStatus(errStatus)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [8:0] expQ[$];
  string tagQ[$];

  // requirement-level model state
  logic mCtl = 0, mEarly = 0, mLate = 0, mMaster = 0, mStat = 0, mHard = 0, mPend = 0;

  // vector: {ctl, early, late, master, status, stopClk, hard, logReq, inhibit}
  task automatic step(input string tag);
    logic anyL, logC, stpC, rstE, eRst, cRst, hitAny, newE, logT, hardT;
    logic nCtl, nEarly, nLate, nMaster, nStat, nHard, nPend;
    anyL   = mCtl | mEarly | mLate;
    logC   = (fB == 3'd2) && (fD == 2'd3);
    stpC   = (fB == 3'd5) && (fD == 2'd3);
    rstE   = (fR == 3'd6) && man && !(en && anyL);
    eRst   = sys | cbtn | rstE;
    cRst   = eRst | lsc;
    hitAny = (|cIn) | (|eIn) | (|lIn);
    newE   = hitAny && !anyL;
    logT   = en && !sys && !mStat && !mHard && (logC || mPend || newE);
    hardT  = en && !sys && ((mStat && newE) || stpC);
    nCtl    = cRst ? 1'b0 : (mCtl | (|cIn) | (logC & !en));
    nEarly  = cRst ? 1'b0 : (mEarly | (|eIn) | stpC);
    nLate   = cRst ? 1'b0 : (mLate | (|lIn));
    nMaster = cRst ? 1'b0 : (mMaster | anyL);
    nStat   = (sys | logT) ? 1'b1 : (rstE ? 1'b0 : mStat);
    nHard   = eRst ? 1'b0 : (mHard | hardT);
    nPend   = (logT | cRst) ? 1'b0 : (mPend | (logC & !en));
    mCtl = nCtl; mEarly = nEarly; mLate = nLate; mMaster = nMaster;
    mStat = nStat; mHard = nHard; mPend = nPend;
    expQ.push_back({mCtl, mEarly, mLate, mMaster, mStat,
                    en & (mCtl | mEarly | mLate), mHard, logT,
                    en & ((|cIn) | (|eIn) | stpC | mCtl | mEarly)});
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle();
    sys = 0; man = 0; cbtn = 0; lsc = 0;
    cIn = '0; eIn = '0; lIn = '0; fB = '0; fD = '0; fR = '0;
  endtask

  // monitor: compare after each active edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      logic [8:0] got, exp;
      string tag;
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      got = {ctlLatch, earlyLatch, lateLatch, masterLatch, errStatus,
             stopClk, hardStop, logReq, csInhibit};
      checks++;
      if (got !== exp) begin
        fails++;
        $display("FAIL %s: got %b expected %b (ctl,early,late,master,status,stop,hard,log,inh)",
                 tag, got, exp);
      end
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(); en = 1; sys = 1;
    step("R10 R8 reset state");
    step("R10 R8 reset state held");
    idle(); fR = 3'd6; man = 1;
    step("R8 R11 reset-errors clears status");
    idle(); cIn = 4'b0010;
    step("R1 R2 R4 R9 control check");
    idle();
    step("R3 master latch");
    idle(); lsc = 1;
    step("R10 log clock start clears latches");
    idle(); lIn = 5'b01000;
    step("R8 R4 late check forces hard stop");
    idle();
    step("R8 idle hold");
    idle(); fR = 3'd6; man = 1;
    step("R11 reset-errors ignored while stopped");
    idle(); cbtn = 1;
    step("R10 check reset clears hard stop");
    idle(); fR = 3'd6; man = 1;
    step("R11 reset-errors while running");
    idle(); en = 0; eIn = 3'b001;
    step("R7 early check while disabled");
    idle(); fB = 3'd2; fD = 2'd3;
    step("R7 LOG held while disabled");
    idle(); en = 1;
    step("R7 R5 pending log-out issued");
    idle(); cbtn = 1; lIn = 5'b00001;
    step("R12 reset wins over error");
    idle(); lIn = 5'b00001;
    step("R12 error captured next cycle");
    idle(); cbtn = 1;
    step("R10 check reset");
    idle(); fR = 3'd6; man = 1;
    step("R8 clear status");
    idle(); fB = 3'd2; fD = 2'd3;
    step("R5 LOG command");
    idle();
    step("R5 pulse ends");
    idle(); fB = 3'd2; fD = 2'd3;
    step("R8 LOG dropped while status set");
    idle(); fB = 3'd5; fD = 2'd3;
    step("R6 STOP enabled");
    idle(); cbtn = 1;
    step("R10 clear after STOP");
    idle(); en = 0; fB = 3'd5; fD = 2'd3;
    step("R6 STOP disabled no hard stop");
    idle(); en = 1; cbtn = 1;
    step("R10 final clear");
    idle(); sys = 1;
    step("R10 R8 system reset again");
    idle();
    step("R1 quiet after reset");
    @(negedge clk); @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule